// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

A 64-entry, 4-bit first-in/first-out buffer that a writer and a reader drive with level strobes and ready flags instead of a clocked enable. The writer raises a put strobe while the put-ready flag is high. The word is captured and the flag drops. When the strobe falls, the write pointer moves on and the flag recovers, unless the buffer has just become full. The reader works the same way. The oldest stored word falls through to the output on its own and is flagged by take-ready. A shift-out pulse consumes it, and once the strobe falls the next word is presented.

Both strobes pass through a two-stage synchronizer into one system clock and are then edge-detected, so the block is fully synchronous. Storage is a register-file RAM addressed by write and read pointers that are one bit wider than the address. An active-low reset empties the buffer. An active-low output enable floats the data outputs without touching the flags or the pointers.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low and just after it is released, put-ready is 1, take-ready is 0 and take-data is 0.
- R2: When put-strobe is high and put-ready is 1, put-data is written and put-ready goes to 0. It stays at 0 until put-strobe falls. On that fall the write pointer advances and put-ready returns to 1 if the buffer is not full.
- R3: The buffer holds exactly 64 words, and the word shown on the output counts among them. Once 64 words are held, put-ready stays 0.
- R4: A put-strobe pulse that starts and ends while put-ready is 0 writes nothing. After the buffer is drained, exactly the 64 earlier words come out, in order.
- R5: If put-strobe is held high while the buffer is full, the word is written in the clock cycle after a read frees a location. Put-ready is then 0 again until put-strobe falls.
- R6: A rising shift-out while take-ready is 1 drops take-ready and leaves the data unchanged. On the falling shift-out the read pointer advances, and the next word is shown with take-ready set to 1.
- R7: When the last word has been consumed, take-ready stays 0 and take-data keeps that last word.
- R8: A word written into an empty buffer is shown with take-ready set to 1 one clock cycle after the write pointer advances.
- R9: A shift-out pulse while take-ready is 0 and the buffer is empty consumes nothing.
- R10: If shift-out is held high while the buffer is empty, a written word is shown with take-ready at 1 for one cycle and is then consumed. Later words wait, and take-data keeps the consumed word, until shift-out falls.
- R11: If put-strobe is high when reset is released, put-data is written, and put-ready stays 0 until put-strobe falls.
- R12: When take-oe-n is 1, take-data is not driven. The flags and the stored contents are unaffected, and the word reappears when take-oe-n returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assertion |
| put_strobe | input | 1 | Shift-in strobe from the writer |
| put_data | input | 4 | Word to store |
| put_ready | output | 1 | High when a word may be written |
| take_strobe | input | 1 | Shift-out strobe from the reader |
| take_ready | output | 1 | High when take_data holds a valid unread word |
| take_oe_n | input | 1 | Active-low output enable for take_data |
| take_data | output | 4 | Head word, three-stated while take_oe_n is high |

## Verification
Any strobe level change is acted on at the third rising clock edge after it is driven: two synchronizer stages, then the control register. The flag responses and pointer moves therefore appear after that edge. A fall-through word arrives one edge later, on the fourth edge. A held put strobe loads its word on the edge after a read frees space, so put-ready is high for exactly one cycle. The bench drives every input on the falling clock edge and counts whole rising edges before each sample. It also checks flags at the edge just before a change where that matters, for example that take-ready is still 0 three edges after a write and 1 after four.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    // Synchronizer depth applied to each asynchronous strobe
    localparam int unsigned SYNC_STAGES = 2;

    // Conditioned strobe as seen by the control logic
    typedef struct packed {
        logic lvl;   // synchronized level
        logic fall;  // one-cycle falling-edge indication
    } strobe_t;

endpackage

// File: rtl/strobe_fifo_sync.sv
module strobe_fifo_sync
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    strobe_in,
    output strobe_t strobe_out
);

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], strobe_in};
    end

    assign strobe_out.lvl  = chain_q[STAGES-1];
    assign strobe_out.fall = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/strobe_fifo_ram.sv
module strobe_fifo_ram #(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_strobe,
    input  logic [DATA_W-1:0] put_data,
    output logic              put_ready,
    input  logic              take_strobe,
    output logic              take_ready,
    input  logic              take_oe_n,
    output logic [DATA_W-1:0] take_data
);

    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned PTR_W = AW + 1;
    localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic              wr_ready;
        logic              wr_pend;   // word captured, pointer advance awaits strobe fall
        logic              rd_valid;
        logic              rd_pend;   // word consumed, pointer advance awaits strobe fall
        logic [DATA_W-1:0] dout;
    } ctl_t;

    ctl_t st_d, st_q;

    strobe_t put_s, take_s;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [PTR_W-1:0]  occ_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    strobe_fifo_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (put_strobe),
        .strobe_out (put_s)
    );

    strobe_fifo_sync #(.STAGES(SYNC_STAGES)) u_take_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_in  (take_strobe),
        .strobe_out (take_s)
    );

    strobe_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (st_q.wptr[AW-1:0]),
        .wdata (put_data),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (ram_rdata)
    );

    assign occ_q = st_q.wptr - st_q.rptr;

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;

        // Write side: capture while strobe is high, advance on its fall
        if (st_q.wr_ready && put_s.lvl && !st_q.wr_pend) begin
            ram_we       = 1'b1;
            st_d.wr_pend = 1'b1;
        end else if (st_q.wr_pend && put_s.fall) begin
            st_d.wptr    = st_q.wptr + 1'b1;
            st_d.wr_pend = 1'b0;
        end

        // Read side: consume while strobe is high, advance on its fall,
        // otherwise let the head word fall through when one is stored
        if (st_q.rd_valid && take_s.lvl && !st_q.rd_pend) begin
            st_d.rd_valid = 1'b0;
            st_d.rd_pend  = 1'b1;
        end else if (st_q.rd_pend && take_s.fall) begin
            st_d.rptr    = st_q.rptr + 1'b1;
            st_d.rd_pend = 1'b0;
        end else if (!st_q.rd_valid && !st_q.rd_pend && occ_q != '0) begin
            st_d.dout     = ram_rdata;
            st_d.rd_valid = 1'b1;
        end

        st_d.wr_ready = !st_d.wr_pend && ((st_d.wptr - st_d.rptr) != FULL_OCC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wptr     <= '0;
            st_q.rptr     <= '0;
            st_q.wr_ready <= 1'b1;
            st_q.wr_pend  <= 1'b0;
            st_q.rd_valid <= 1'b0;
            st_q.rd_pend  <= 1'b0;
            st_q.dout     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign put_ready  = st_q.wr_ready;
    assign take_ready = st_q.rd_valid;
    assign take_data  = take_oe_n ? 'z : st_q.dout;
    assign wr_ptr     = st_q.wptr;
    assign rd_ptr     = st_q.rptr;

endmodule

// File: rtl/strobe_fifo_checker.sv
module strobe_fifo_checker #(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              put_ready,
    input logic              take_ready,
    input logic [PTR_W-1:0]  wptr,
    input logic [PTR_W-1:0]  rptr,
    input logic [DATA_W-1:0] held_word
);

    localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH);

    logic [PTR_W-1:0] occ;
    assign occ = wptr - rptr;

    // R3: occupancy never passes capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC);

    // R3: a full buffer never offers a write slot
    a_r3_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL_OCC) |-> !put_ready);

    // R2: write pointer moves by one location at most per cycle
    a_r2_wptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr != $past(wptr)) |-> (wptr == $past(wptr) + 1'b1));

    // R6: read pointer moves by one location at most per cycle
    a_r6_rptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr != $past(rptr)) |-> (rptr == $past(rptr) + 1'b1));

    // R8: output becomes valid only when a stored word exists
    a_r8_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_ready) |-> ($past(occ) != '0));

    // R7: while nothing valid is shown, the held word does not change
    a_r7_idle_output_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_ready && !$past(take_ready)) |-> $stable(held_word));

endmodule

bind strobe_fifo strobe_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_strobe_fifo_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .put_ready  (put_ready),
    .take_ready (take_ready),
    .wptr       (wr_ptr),
    .rptr       (rd_ptr),
    .held_word  (st_q.dout)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       put_strobe = 1'b0;
    logic [3:0] put_data = 4'h0;
    logic       take_strobe = 1'b0;
    logic       take_oe_n = 1'b0;
    wire        put_ready;
    wire        take_ready;
    wire [3:0]  take_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    strobe_fifo u_strobe_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .put_strobe  (put_strobe),
        .put_data    (put_data),
        .put_ready   (put_ready),
        .take_strobe (take_strobe),
        .take_ready  (take_ready),
        .take_oe_n   (take_oe_n),
        .take_data   (take_data)
    );

    // Wait n rising edges, then settle on the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full write handshake; ready_after is the expected flag after the fall
    task automatic push(input logic [3:0] v, input logic ready_after);
        put_data   = v;
        put_strobe = 1'b1;
        tick(3);
        chk("R2 ready drops on capture", {7'd0, put_ready}, 8'd0);
        put_strobe = 1'b0;
        tick(3);
        chk("R2 ready after strobe fall", {7'd0, put_ready}, {7'd0, ready_after});
    endtask

    // Full read handshake, ends four edges after the strobe falls
    task automatic pop();
        take_strobe = 1'b1;
        tick(3);
        chk("R6 take_ready drops on shift-out", {7'd0, take_ready}, 8'd0);
        take_strobe = 1'b0;
        tick(4);
    endtask

    function automatic logic [3:0] pattern(input int i, input logic [3:0] salt);
        return 4'((i * 5 + 3)) ^ salt;
    endfunction

    task automatic t_reset();
        tick(2);
        chk("R1 reset put_ready", {7'd0, put_ready}, 8'd1);
        chk("R1 reset take_ready", {7'd0, take_ready}, 8'd0);
        chk("R1 reset take_data", {4'd0, take_data}, 8'h00);
        rst_n = 1'b1;
        tick(2);
        chk("R1 idle after release", {6'd0, put_ready, take_ready}, 8'b10);
    endtask

    task automatic t_fall_through();
        put_data   = 4'hA;
        put_strobe = 1'b1;
        tick(3);
        chk("R2 capture clears ready", {7'd0, put_ready}, 8'd0);
        put_strobe = 1'b0;
        tick(3);
        chk("R2 ready returns", {7'd0, put_ready}, 8'd1);
        chk("R8 not yet shown at pointer advance", {7'd0, take_ready}, 8'd0);
        tick(1);
        chk("R8 fall-through valid", {7'd0, take_ready}, 8'd1);
        chk("R8 fall-through data", {4'd0, take_data}, 8'h0A);
    endtask

    task automatic t_read_sequence();
        push(4'hB, 1'b1);
        push(4'hC, 1'b1);
        take_strobe = 1'b1;
        tick(3);
        chk("R6 data held while consumed", {4'd0, take_data}, 8'h0A);
        take_strobe = 1'b0;
        tick(4);
        chk("R6 next word valid", {7'd0, take_ready}, 8'd1);
        chk("R6 next word data", {4'd0, take_data}, 8'h0B);
        pop();
        chk("R6 third word", {3'd0, take_ready, take_data}, 8'h1C);
        pop();
        chk("R7 empty valid low", {7'd0, take_ready}, 8'd0);
        chk("R7 last word retained", {4'd0, take_data}, 8'h0C);
        // R9: shift-out pulse on an empty buffer
        take_strobe = 1'b1;
        tick(3);
        take_strobe = 1'b0;
        tick(4);
        chk("R9 ignored pulse keeps data", {3'd0, take_ready, take_data}, 8'h0C);
        push(4'hD, 1'b1);
        tick(1);
        chk("R9 following word not lost", {3'd0, take_ready, take_data}, 8'h1D);
        pop();
        chk("R9 drained", {7'd0, take_ready}, 8'd0);
    endtask

    task automatic fill(input logic [3:0] salt);
        for (int i = 0; i < 64; i++) push(pattern(i, salt), (i != 63));
    endtask

    task automatic t_full_ignore();
        fill(4'h0);
        chk("R3 full keeps ready low", {7'd0, put_ready}, 8'd0);
        put_data   = 4'hF;
        put_strobe = 1'b1;
        tick(3);
        chk("R4 ready low during ignored pulse", {7'd0, put_ready}, 8'd0);
        put_strobe = 1'b0;
        tick(3);
        chk("R4 ready low after ignored pulse", {7'd0, put_ready}, 8'd0);
        for (int i = 0; i < 64; i++) begin
            chk("R4 drained word", {3'd0, take_ready, take_data}, {3'd0, 1'b1, pattern(i, 4'h0)});
            pop();
        end
        chk("R4 no extra word", {7'd0, take_ready}, 8'd0);
        chk("R3 ready after drain", {7'd0, put_ready}, 8'd1);
    endtask

    task automatic t_held_put();
        fill(4'h6);
        put_data   = 4'h5;
        put_strobe = 1'b1;
        tick(3);
        chk("R5 held while full", {7'd0, put_ready}, 8'd0);
        pop();
        chk("R5 loaded after space frees", {7'd0, put_ready}, 8'd0);
        put_strobe = 1'b0;
        tick(3);
        chk("R5 full again after fall", {7'd0, put_ready}, 8'd0);
        for (int i = 1; i < 64; i++) begin
            chk("R5 drained word", {3'd0, take_ready, take_data}, {3'd0, 1'b1, pattern(i, 4'h6)});
            pop();
        end
        chk("R5 held word last", {3'd0, take_ready, take_data}, 8'h15);
        pop();
        chk("R5 empty", {7'd0, take_ready}, 8'd0);
    endtask

    task automatic t_held_take();
        take_strobe = 1'b1;
        tick(3);
        push(4'h9, 1'b1);
        tick(1);
        chk("R10 word shown", {3'd0, take_ready, take_data}, 8'h19);
        tick(1);
        chk("R10 word consumed", {3'd0, take_ready, take_data}, 8'h09);
        push(4'h6, 1'b1);
        tick(2);
        chk("R10 later word waits", {3'd0, take_ready, take_data}, 8'h09);
        take_strobe = 1'b0;
        tick(4);
        chk("R10 later word after release", {3'd0, take_ready, take_data}, 8'h16);
        pop();
        chk("R10 empty", {7'd0, take_ready}, 8'd0);
    endtask

    task automatic t_output_enable();
        push(4'h3, 1'b1);
        tick(1);
        take_oe_n = 1'b1;
        tick(1);
        chk("R12 outputs released", {7'd0, (take_data !== 4'h3)}, 8'd1);
        chk("R12 flags unaffected", {6'd0, put_ready, take_ready}, 8'b11);
        take_oe_n = 1'b0;
        tick(1);
        chk("R12 word reappears", {3'd0, take_ready, take_data}, 8'h13);
        pop();
        chk("R12 empty", {7'd0, take_ready}, 8'd0);
    endtask

    task automatic t_reset_with_put();
        put_data   = 4'hC;
        put_strobe = 1'b1;
        rst_n      = 1'b0;
        tick(2);
        chk("R1 reset clears data", {2'd0, put_ready, take_ready, take_data}, 8'h20);
        rst_n = 1'b1;
        tick(3);
        chk("R11 written on release", {7'd0, put_ready}, 8'd0);
        put_strobe = 1'b0;
        tick(3);
        chk("R11 ready after fall", {7'd0, put_ready}, 8'd1);
        tick(1);
        chk("R11 word falls through", {3'd0, take_ready, take_data}, 8'h1C);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fall_through();
        t_read_sequence();
        t_full_ignore();
        t_held_put();
        t_held_take();
        t_output_enable();
        t_reset_with_put();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule